// File: doc/BRIEF.md
# Nibble-Serial Frame Check Sequence Checker

This block checks the 32-bit cyclic redundancy code that protects an Ethernet frame. It receives the frame four bits per clock, as a media-independent receive path delivers it. Upstream framing logic strips the preamble and start delimiter. It then hands the block every remaining nibble of the frame, including the four trailing check bytes. A start-of-frame pulse clears the block before each frame.

The checker keeps a 32-bit remainder. This remainder is preset to all ones and advanced by one nibble on each clock that carries a valid nibble. Within each nibble, receive bit 0 is the earliest bit on the wire. The bits are therefore mirrored before they enter the division, so that the earliest bit is consumed first. Because the check bytes are divided along with the data, an intact frame leaves a fixed residue in the remainder. The error output is high whenever the remainder differs from that residue, so it falls low only when a frame has arrived intact.

Top module: `crc_nibble_check`

## Requirements
- R1: While reset is asserted and after it is released, the remainder is all ones and `crc_err` is high.
- R2: Within each nibble, `nib_data[0]` is the earliest line bit and is divided first, followed by bits 1, 2 and 3. The mirror stage maps `nib_data[3]` to divider input bit 0. A frame whose nibbles are delivered in any other bit order reports an error.
- R3: The remainder advances by exactly one nibble on each clock with `nib_vld` high and `sof` low. Clocks with `nib_vld` low leave the remainder and `crc_err` unchanged, so idle gaps inside a frame have no effect.
- R4: A clock with `sof` high presets the remainder to all ones, and `crc_err` is high on the following cycle. A nibble presented on that same clock is discarded.
- R5: The division uses the generator 0x04C11DB7, with bits shifted in at the low end and feedback taken from bit 31. The frame's four check bytes are the complemented remainder, sent high-order bit first. An intact frame of any length leaves the residue 0xC704DD7B, and `crc_err` is low from the cycle after its last nibble is accepted.
- R6: Any frame with a single inverted bit, whether in the data or in the check bytes, leaves `crc_err` high.
- R7: `crc_err` depends only on the stored remainder. In the cycle after every accepted nibble, it equals the inequality of the remainder against 0xC704DD7B.
- R8: Frames may follow each other with only a `sof` pulse between them. A frame abandoned part way through has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof | input | 1 | Start-of-frame clear; presets the remainder |
| nib_vld | input | 1 | Qualifies `nib_data` on this clock |
| nib_data | input | 4 | Receive nibble; bit 0 is the earliest line bit |
| crc_err | output | 1 | High unless the remainder holds the good-frame residue |

## Verification
The assertions assume that `sof`, `nib_vld` and `nib_data` are known and stable around each rising edge. They also assume that a frame is closed only by a `sof` pulse, never by reset alone. The bench changes inputs only on falling edges and always opens a frame with `sof`. It inserts idle gaps only as clocks with `nib_vld` low, so every stimulus falls inside those assumptions. Where a frame is deliberately abandoned or delivered with nibbles in the wrong order, the inputs are still well-formed; only the data content is wrong.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;

   typedef enum logic [0:0] {
      ORDER_MIRROR = 1'b0,
      ORDER_DIRECT = 1'b1
   } bit_order_e;

   localparam int unsigned DEF_CRC_W   = 32;
   localparam int unsigned DEF_NIB_W   = 4;
   localparam logic [31:0] DEF_POLY    = 32'h04C1_1DB7;
   localparam logic [31:0] DEF_INIT    = 32'hFFFF_FFFF;
   localparam logic [31:0] DEF_RESIDUE = 32'hC704_DD7B;

endpackage

// File: rtl/nib_order.sv
module nib_order
   import crc_nib_pkg::*;
#(
   parameter int unsigned NIB_W = DEF_NIB_W,
   parameter bit_order_e  ORDER = ORDER_MIRROR
) (
   input  logic [NIB_W-1:0] line_nib,
   output logic [NIB_W-1:0] div_nib
);

   generate
      if (NIB_W < 1) begin : g_bad_width
         $error("nib_order: NIB_W must be at least 1");
      end

      if (ORDER == ORDER_MIRROR) begin : g_mirror
         for (genvar b = 0; b < NIB_W; b++) begin : g_bit
            assign div_nib[b] = line_nib[NIB_W-1-b];
         end
      end else begin : g_direct
         assign div_nib = line_nib;
      end
   endgenerate

endmodule

// File: rtl/crc_nib_step.sv
module crc_nib_step
   import crc_nib_pkg::*;
#(
   parameter int unsigned      CRC_W = DEF_CRC_W,
   parameter int unsigned      NIB_W = DEF_NIB_W,
   parameter logic [CRC_W-1:0] POLY  = DEF_POLY
) (
   input  logic [CRC_W-1:0] rem_cur,
   input  logic [NIB_W-1:0] div_nib,
   output logic [CRC_W-1:0] rem_nxt
);

   generate
      if (CRC_W < NIB_W) begin : g_bad_ratio
         $error("crc_nib_step: CRC_W must not be below NIB_W");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc_nib_step: generator needs its constant term");
      end
   endgenerate

   // Divider input bit NIB_W-1 is consumed first.
   logic [CRC_W-1:0] stage [NIB_W+1];

   assign stage[0] = rem_cur;

   generate
      for (genvar k = 0; k < NIB_W; k++) begin : g_stage
         logic fb;
         assign fb = stage[k][CRC_W-1] ^ div_nib[NIB_W-1-k];
         assign stage[k+1] = {stage[k][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   assign rem_nxt = stage[NIB_W];

endmodule

// File: rtl/crc_nib_state.sv
module crc_nib_state
   import crc_nib_pkg::*;
#(
   parameter int unsigned      CRC_W = DEF_CRC_W,
   parameter logic [CRC_W-1:0] INIT  = DEF_INIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CRC_W-1:0] rem_nxt,
   output logic [CRC_W-1:0] rem_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= INIT;
      end else if (clr) begin
         rem_q <= INIT;
      end else if (adv) begin
         rem_q <= rem_nxt;
      end
   end

   AST_RESET_PRESET : assert property (@(posedge clk)
      !rst_n |=> rem_q == INIT); // R1

   AST_CLEAR_PRESET : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> rem_q == INIT); // R4

   AST_IDLE_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(rem_q)); // R3

   AST_ADVANCE_TAKEN : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && adv) |=> rem_q == $past(rem_nxt)); // R3

endmodule

// File: rtl/crc_nibble_check.sv
module crc_nibble_check
   import crc_nib_pkg::*;
#(
   parameter int unsigned      CRC_W   = DEF_CRC_W,
   parameter int unsigned      NIB_W   = DEF_NIB_W,
   parameter logic [CRC_W-1:0] POLY    = DEF_POLY,
   parameter logic [CRC_W-1:0] INIT    = DEF_INIT,
   parameter logic [CRC_W-1:0] RESIDUE = DEF_RESIDUE,
   parameter bit_order_e       ORDER   = ORDER_MIRROR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             nib_vld,
   input  logic [NIB_W-1:0] nib_data,
   output logic             crc_err
);

   generate
      if (INIT == RESIDUE) begin : g_bad_residue
         $error("crc_nibble_check: preset must differ from the residue");
      end
   endgenerate

   logic [NIB_W-1:0] div_nib;
   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] rem_nxt;
   logic             adv;

   // A nibble arriving with the clear is dropped.
   assign adv = nib_vld & ~sof;

   nib_order #(
      .NIB_W (NIB_W),
      .ORDER (ORDER)
   ) u_order (
      .line_nib (nib_data),
      .div_nib  (div_nib)
   );

   crc_nib_step #(
      .CRC_W (CRC_W),
      .NIB_W (NIB_W),
      .POLY  (POLY)
   ) u_step (
      .rem_cur (rem_q),
      .div_nib (div_nib),
      .rem_nxt (rem_nxt)
   );

   crc_nib_state #(
      .CRC_W (CRC_W),
      .INIT  (INIT)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (sof),
      .adv     (adv),
      .rem_nxt (rem_nxt),
      .rem_q   (rem_q)
   );

   assign crc_err = (rem_q != RESIDUE);

   AST_ERR_AFTER_SOF : assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> crc_err); // R4

   AST_ERR_IDLE_STABLE : assert property (@(posedge clk) disable iff (!rst_n)
      (!sof && !nib_vld) |=> $stable(crc_err)); // R3

   AST_ERR_KNOWN : assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(crc_err)); // R7

endmodule

// File: tb/crc_nibble_check_bench.sv
module crc_nibble_check_bench;

   localparam logic [31:0] GEN   = 32'h04C1_1DB7;
   localparam logic [31:0] GOOD  = 32'hC704_DD7B;
   localparam int          MAXB  = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof = 1'b0;
   logic       nib_vld = 1'b0;
   logic [3:0] nib_data = 4'h0;
   logic       crc_err;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0]  fbuf [MAXB];
   logic [31:0] model = 32'hFFFF_FFFF;

   always #5 clk = ~clk;

   crc_nibble_check u_crc_nibble_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (sof),
      .nib_vld  (nib_vld),
      .nib_data (nib_data),
      .crc_err  (crc_err)
   );

   function automatic logic [31:0] ser_bit(input logic [31:0] s, input logic b);
      logic fb;
      fb = s[31] ^ b;
      return {s[30:0], 1'b0} ^ (fb ? GEN : 32'h0);
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic act, input logic exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: crc_err=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_sof(input bit with_nib, input logic [3:0] d);
      @(negedge clk);
      sof = 1'b1; nib_vld = with_nib; nib_data = d;
      @(negedge clk);
      sof = 1'b0; nib_vld = 1'b0;
      model = 32'hFFFF_FFFF;
   endtask

   // Drive one nibble; the bit-serial model consumes bit 0 first.
   task automatic push_nib(input logic [3:0] d, input int gap);
      @(negedge clk);
      nib_vld = 1'b1; nib_data = d;
      for (int b = 0; b < 4; b++) model = ser_bit(model, d[b]);
      @(negedge clk);
      nib_vld = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
   endtask

   // Build data bytes then append the complemented check value.
   task automatic build(input int nbytes, input int seed);
      logic [31:0] s;
      logic [31:0] fcs;
      s = 32'hFFFF_FFFF;
      for (int i = 0; i < nbytes; i++) begin
         fbuf[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
         for (int b = 0; b < 8; b++) s = ser_bit(s, fbuf[i][b]);
      end
      fcs = ~s;
      for (int k = 0; k < 4; k++) fbuf[nbytes+k] = rev8(fcs[31-8*k -: 8]);
   endtask

   task automatic send(input int total, input int gap, input bit swap);
      for (int i = 0; i < total; i++) begin
         if (!swap) begin
            push_nib(fbuf[i][3:0], gap);
            push_nib(fbuf[i][7:4], gap);
         end else begin
            push_nib(rev8(fbuf[i])[7:4], gap);
            push_nib(rev8(fbuf[i])[3:0], gap);
         end
      end
   endtask

   initial begin : watchdog
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (finished) disable watchdog;
      end
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(crc_err === 1'b1, "R1", crc_err, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check(crc_err === 1'b1, "R1", crc_err, 1'b1);

      // R5 and R3: intact frames of many lengths, gaps on odd lengths
      for (int len = 1; len <= 20; len++) begin
         build(len, len);
         do_sof(1'b0, 4'h0);
         check(crc_err === 1'b1, "R4", crc_err, 1'b1);
         send(len + 4, (len % 2) ? (len % 3) + 1 : 0, 1'b0);
         check(crc_err === 1'b0, "R5", crc_err, 1'b0);
         check(crc_err === (model != GOOD), "R7", crc_err, model != GOOD);
      end

      // R7: one more nibble after an intact frame follows the model
      push_nib(4'h0, 0);
      check(crc_err === (model != GOOD), "R7", crc_err, model != GOOD);
      push_nib(4'hA, 2);
      check(crc_err === (model != GOOD), "R7", crc_err, model != GOOD);

      // R6: every single-bit inversion of an 8-byte frame
      for (int j = 0; j < 96; j++) begin
         build(8, 3);
         fbuf[j/8][j%8] = ~fbuf[j/8][j%8];
         do_sof(1'b0, 4'h0);
         send(12, 0, 1'b0);
         check(crc_err === 1'b1, "R6", crc_err, 1'b1);
      end

      // R2: nibbles delivered with wrong bit order must fail
      build(6, 9);
      do_sof(1'b0, 4'h0);
      send(10, 0, 1'b1);
      check(crc_err === 1'b1, "R2", crc_err, 1'b1);
      do_sof(1'b0, 4'h0);
      send(10, 0, 1'b0);
      check(crc_err === 1'b0, "R2", crc_err, 1'b0);

      // R4: nibble on the clear cycle is discarded
      build(5, 4);
      do_sof(1'b1, 4'hF);
      check(crc_err === 1'b1, "R4", crc_err, 1'b1);
      send(9, 1, 1'b0);
      check(crc_err === 1'b0, "R4", crc_err, 1'b0);

      // R8: abandoned frame, then back-to-back intact frames
      build(7, 2);
      do_sof(1'b0, 4'h0);
      send(4, 0, 1'b0);
      build(3, 8);
      do_sof(1'b0, 4'h0);
      send(7, 0, 1'b0);
      check(crc_err === 1'b0, "R8", crc_err, 1'b0);
      build(11, 6);
      do_sof(1'b0, 4'h0);
      send(15, 0, 1'b0);
      check(crc_err === 1'b0, "R8", crc_err, 1'b0);

      // R3: long idle stretch leaves the result unchanged
      repeat (10) @(negedge clk);
      check(crc_err === 1'b0, "R3", crc_err, 1'b0);

      // R1: reset mid-frame returns to the preset state
      do_sof(1'b0, 4'h0);
      send(3, 0, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(crc_err === 1'b1, "R1", crc_err, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule